// File: doc/BRIEF.md
# Floating-Point Issue Scoreboard

This block decides, one decoded floating-point operation per cycle, whether the operation may leave the integer pipeline. It sends operations to one of two units. The first is a fully pipelined arithmetic unit that accepts a new operation every cycle. The second is a serial divide/square-root unit that holds one operation at a time and runs beside the pipelined one. A register is pending from the cycle its producer issues until the cycle its result is written. The block raises `stall` only when an operand is still pending, when a destination would be overwritten out of order, or when a unit or the single write port is taken.

Pipelined results pass through three unit stages and one extra forwarding stage. A consumer can therefore issue in the fourth cycle after its producer, taking the operand from the bypass. Divide and square-root latency is set by parameter, with separate single and double values. When a pipelined result and a divide result are due in the same cycle, the pipelined one writes first and the divide result follows one cycle later. The arithmetic itself is not modelled.

Top module: `fpsb_issue_ctrl`

## Requirements
- R1: After reset, with `op_valid` low, `stall`, `pipe_issue`, `div_issue`, `fwd_src1`, `fwd_src2` and `wb_valid` are all 0.
- R2: An operation with `op_kind[1]`=0 that meets no hazard raises `pipe_issue` in the same cycle, and such operations can issue in consecutive cycles.
- R3: A pipelined operation issued in cycle c with `dst_use`=1 produces `wb_valid`=1, `wb_reg`=dst and `wb_from_div`=0 in cycle c+4. With `dst_use`=0 it writes nothing.
- R4: A consumer whose source is being written back in the current cycle issues in that cycle, with `fwd_src1`/`fwd_src2` high for each matching source in use. The forwarding flags are otherwise low.
- R5: `op_kind`=2'b10 (single) and 2'b11 (double) issue to the divide unit. The result is written in cycle c+DIV_LAT_SGL or c+DIV_LAT_DBL, with `wb_from_div`=1. Divide operations always write `dst_idx`.
- R6: A divide operation stalls while an earlier divide result is unwritten. It may issue in the cycle that result is written back.
- R7: Pipelined operations free of hazards keep issuing and writing back while a divide is in flight.
- R8: A source with its use flag set that matches an in-flight destination not written back this cycle stalls the operation. A source whose use flag is 0 never causes a stall.
- R9: A pipelined operation with `dst_use`=1 whose destination equals the in-flight divide destination stalls until the cycle the divide result is written.
- R10: If a pipelined result and a divide result are due in the same cycle, the pipelined result is written in that cycle and the divide result in the next.
- R11: A pipelined operation stalls if it would otherwise write back in the cycle reserved for a held divide result. This happens when a writing pipelined operation issued in the previous cycle and the divide result falls due three cycles later.
- R12: `stall` is never high while `op_valid` is low, at most one issue strobe is high, and no strobe is high while `stall` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A decoded operation is presented |
| op_kind | input | 2 | Bit 1: divide unit; bit 0: double precision (divide latency) |
| src1_use | input | 1 | First source is read |
| src1_idx | input | REG_W | First source register |
| src2_use | input | 1 | Second source is read |
| src2_idx | input | REG_W | Second source register |
| dst_use | input | 1 | Pipelined operation writes a destination |
| dst_idx | input | REG_W | Destination register |
| stall | output | 1 | Hold the presented operation |
| pipe_issue | output | 1 | Operation starts in the pipelined unit |
| div_issue | output | 1 | Operation starts in the divide unit |
| fwd_src1 | output | 1 | First source taken from the write-back bypass |
| fwd_src2 | output | 1 | Second source taken from the write-back bypass |
| wb_valid | output | 1 | A result is written this cycle |
| wb_reg | output | REG_W | Register written |
| wb_from_div | output | 1 | Written result comes from the divide unit |

## Verification
The stall, issue and forwarding outputs are combinational on the presented operation and are due in that same cycle. Pipelined write-backs are due exactly four cycles after issue. Divide write-backs are due 15 or 23 cycles after issue, plus one cycle when a write-port clash occurs. The bench keeps a cycle count and a table of due cycles for every register and write slot, and it computes each expected value for the current cycle before the clock edge. It applies inputs after the falling edge and compares one time unit later, so every comparison lands in the cycle in which the result is due.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;
  // Operation kind: bit 1 selects the divide unit, bit 0 double precision
  typedef enum logic [1:0] {
    KIND_PIPE_S = 2'b00,
    KIND_PIPE_D = 2'b01,
    KIND_DIV_S  = 2'b10,
    KIND_DIV_D  = 2'b11
  } op_kind_e;

  function automatic logic kind_is_div(input logic [1:0] k);
    return k[1];
  endfunction

  function automatic logic kind_is_dbl(input logic [1:0] k);
    return k[0];
  endfunction
endpackage

// File: rtl/fpsb_rst_sync.sv
module fpsb_rst_sync (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/fpsb_pipe_track.sv
module fpsb_pipe_track #(
  parameter int REG_W = 5,
  parameter int DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_vld,
  input  logic [REG_W-1:0]            in_rd,
  output logic [DEPTH-1:0]            st_vld,
  output logic [DEPTH-1:0][REG_W-1:0] st_rd
);
  logic [DEPTH-1:0]            vld_d, vld_q;
  logic [DEPTH-1:0][REG_W-1:0] rd_d, rd_q;

  // Stage 0 is loaded at issue; later stages shift one per cycle
  always_comb begin
    vld_d[0] = in_vld;
    rd_d[0]  = in_rd;
  end

  generate
    for (genvar g = 1; g < DEPTH; g++) begin : g_shift
      always_comb begin
        vld_d[g] = vld_q[g-1];
        rd_d[g]  = rd_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rd_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rd_q  <= rd_d;
    end
  end

  assign st_vld = vld_q;
  assign st_rd  = rd_q;
endmodule

// File: rtl/fpsb_div_track.sv
module fpsb_div_track #(
  parameter int REG_W   = 5,
  parameter int LAT_SGL = 15,
  parameter int LAT_DBL = 23,
  parameter int RESV_AT = 3,
  localparam int LAT_MAX = (LAT_SGL > LAT_DBL) ? LAT_SGL : LAT_DBL,
  localparam int CW      = $clog2(LAT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_dbl,
  input  logic [REG_W-1:0] start_rd,
  input  logic             pipe_wb,
  output logic             div_wb,
  output logic [REG_W-1:0] div_rd,
  output logic             div_live,
  output logic             div_resv
);
  logic             act_q, act_d;
  logic             held_q, held_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [REG_W-1:0] rd_q, rd_d;
  logic             cnt_en, done;

  assign done   = act_q & ~held_q & (cnt_q == '0);
  assign div_wb = (done & ~pipe_wb) | held_q;
  assign cnt_en = act_q & (cnt_q != '0);

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    rd_d   = rd_q;
    held_d = done & pipe_wb;
    if (cnt_en) cnt_d = cnt_q - 1'b1;
    if (start) begin
      act_d  = 1'b1;
      rd_d   = start_rd;
      held_d = 1'b0;
      cnt_d  = start_dbl ? CW'(LAT_DBL - 1) : CW'(LAT_SGL - 1);
    end else if (div_wb) begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      held_q <= 1'b0;
      cnt_q  <= '0;
      rd_q   <= '0;
    end else begin
      act_q  <= act_d;
      held_q <= held_d;
      cnt_q  <= cnt_d;
      rd_q   <= rd_d;
    end
  end

  assign div_rd   = rd_q;
  assign div_live = act_q & ~div_wb;
  assign div_resv = act_q & ~held_q & (cnt_q == CW'(RESV_AT));

  // R10: a held result always finds the write port free
  p_held_port_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> !pipe_wb);
  // R10: a result is held for one cycle only
  p_hold_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |=> !held_q);
endmodule

// File: rtl/fpsb_hazard.sv
module fpsb_hazard #(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5,
  parameter int LIVE_N   = 3
) (
  input  logic                         op_valid,
  input  logic                         op_is_div,
  input  logic                         src1_use,
  input  logic [REG_W-1:0]             src1_idx,
  input  logic                         src2_use,
  input  logic [REG_W-1:0]             src2_idx,
  input  logic                         dst_use,
  input  logic [REG_W-1:0]             dst_idx,
  input  logic [LIVE_N-1:0]            st_vld,
  input  logic [LIVE_N-1:0][REG_W-1:0] st_rd,
  input  logic                         div_live,
  input  logic [REG_W-1:0]             div_rd,
  input  logic                         div_resv,
  input  logic                         wb_valid,
  input  logic [REG_W-1:0]             wb_reg,
  output logic                         stall,
  output logic                         pipe_go,
  output logic                         div_go,
  output logic                         fwd1,
  output logic                         fwd2
);
  logic [LIVE_N-1:0][NUM_REGS-1:0] stage_mask;
  logic [NUM_REGS-1:0]             pend;
  logic raw, waw, port_busy, go;

  // Per-register pending vector: results still owed after this cycle
  generate
    for (genvar g = 0; g < LIVE_N; g++) begin : g_mask
      assign stage_mask[g] = st_vld[g] ? (NUM_REGS'(1) << st_rd[g]) : '0;
    end
  endgenerate

  always_comb begin
    pend = div_live ? (NUM_REGS'(1) << div_rd) : '0;
    for (int i = 0; i < LIVE_N; i++) pend = pend | stage_mask[i];
  end

  assign raw       = (src1_use & pend[src1_idx]) | (src2_use & pend[src2_idx]);
  assign waw       = ~op_is_div & dst_use & div_live & (dst_idx == div_rd);
  assign port_busy = op_is_div ? div_live : (div_resv & st_vld[0]);

  assign stall   = op_valid & (raw | waw | port_busy);
  assign go      = op_valid & ~stall;
  assign pipe_go = go & ~op_is_div;
  assign div_go  = go & op_is_div;
  assign fwd1    = go & src1_use & wb_valid & (wb_reg == src1_idx);
  assign fwd2    = go & src2_use & wb_valid & (wb_reg == src2_idx);
endmodule

// File: rtl/fpsb_issue_ctrl.sv
module fpsb_issue_ctrl
  import fpsb_pkg::*;
#(
  parameter int NUM_REGS    = 32,
  parameter int PIPE_LAT    = 3,
  parameter int FWD_STAGES  = 1,
  parameter int DIV_LAT_SGL = 15,
  parameter int DIV_LAT_DBL = 23,
  localparam int REG_W      = $clog2(NUM_REGS),
  localparam int TRK_DEPTH  = PIPE_LAT + FWD_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [1:0]       op_kind,
  input  logic             src1_use,
  input  logic [REG_W-1:0] src1_idx,
  input  logic             src2_use,
  input  logic [REG_W-1:0] src2_idx,
  input  logic             dst_use,
  input  logic [REG_W-1:0] dst_idx,
  output logic             stall,
  output logic             pipe_issue,
  output logic             div_issue,
  output logic             fwd_src1,
  output logic             fwd_src2,
  output logic             wb_valid,
  output logic [REG_W-1:0] wb_reg,
  output logic             wb_from_div
);
  logic                            rst_sn;
  logic [TRK_DEPTH-1:0]            st_vld;
  logic [TRK_DEPTH-1:0][REG_W-1:0] st_rd;
  logic                            pipe_wb, div_wb, div_live, div_resv;
  logic [REG_W-1:0]                div_rd;

  fpsb_rst_sync u_rst (
    .clk    (clk),
    .rst_an (rst_n),
    .rst_sn (rst_sn)
  );

  fpsb_pipe_track #(.REG_W(REG_W), .DEPTH(TRK_DEPTH)) u_pipe (
    .clk    (clk),
    .rst_n  (rst_sn),
    .in_vld (pipe_issue & dst_use),
    .in_rd  (dst_idx),
    .st_vld (st_vld),
    .st_rd  (st_rd)
  );

  assign pipe_wb = st_vld[TRK_DEPTH-1];

  fpsb_div_track #(
    .REG_W   (REG_W),
    .LAT_SGL (DIV_LAT_SGL),
    .LAT_DBL (DIV_LAT_DBL),
    .RESV_AT (TRK_DEPTH - 1)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_sn),
    .start     (div_issue),
    .start_dbl (kind_is_dbl(op_kind)),
    .start_rd  (dst_idx),
    .pipe_wb   (pipe_wb),
    .div_wb    (div_wb),
    .div_rd    (div_rd),
    .div_live  (div_live),
    .div_resv  (div_resv)
  );

  // Single write port: the pipelined result has priority
  assign wb_valid    = pipe_wb | div_wb;
  assign wb_reg      = pipe_wb ? st_rd[TRK_DEPTH-1] : div_rd;
  assign wb_from_div = ~pipe_wb & div_wb;

  fpsb_hazard #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .LIVE_N   (TRK_DEPTH - 1)
  ) u_haz (
    .op_valid  (op_valid),
    .op_is_div (kind_is_div(op_kind)),
    .src1_use  (src1_use),
    .src1_idx  (src1_idx),
    .src2_use  (src2_use),
    .src2_idx  (src2_idx),
    .dst_use   (dst_use),
    .dst_idx   (dst_idx),
    .st_vld    (st_vld[TRK_DEPTH-2:0]),
    .st_rd     (st_rd[TRK_DEPTH-2:0]),
    .div_live  (div_live),
    .div_rd    (div_rd),
    .div_resv  (div_resv),
    .wb_valid  (wb_valid),
    .wb_reg    (wb_reg),
    .stall     (stall),
    .pipe_go   (pipe_issue),
    .div_go    (div_issue),
    .fwd1      (fwd_src1),
    .fwd2      (fwd_src2)
  );

  // R12: idle input never stalls; strobes exclusive
  p_idle_no_stall_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    !op_valid |-> !stall);
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({pipe_issue, div_issue}));
  // R6: no divide starts while another divide result is owed
  p_div_single_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    div_issue |-> !div_live);
  // R9: no pipelined write may target the owed divide destination
  p_waw_block_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (pipe_issue && dst_use && div_live) |-> (dst_idx != div_rd));
  // R4: a forwarded operand matches the register being written
  p_fwd_match_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    fwd_src1 |-> (wb_valid && wb_reg == src1_idx));
endmodule

// File: tb/fpsb_issue_ctrl_test.sv
`timescale 1ns/1ps
module fpsb_issue_ctrl_test;
  localparam int TRK = 4;
  localparam int LS  = 15;
  localparam int LD  = 23;
  localparam int BIG = 1 << 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op_kind = 2'b00;
  logic src1_use = 1'b0, src2_use = 1'b0, dst_use = 1'b0;
  logic [4:0] src1_idx = '0, src2_idx = '0, dst_idx = '0;
  logic stall, pipe_issue, div_issue, fwd_src1, fwd_src2, wb_valid, wb_from_div;
  logic [4:0] wb_reg;

  always #2.5 clk = ~clk;

  fpsb_issue_ctrl uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .src1_use(src1_use), .src1_idx(src1_idx), .src2_use(src2_use), .src2_idx(src2_idx),
    .dst_use(dst_use), .dst_idx(dst_idx), .stall(stall), .pipe_issue(pipe_issue),
    .div_issue(div_issue), .fwd_src1(fwd_src1), .fwd_src2(fwd_src2),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_from_div(wb_from_div)
  );

  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 0;
  bit pw_v[8];
  logic [4:0] pw_r[8];
  bit prev_w = 0;
  bit dv_act = 0;
  logic [4:0] dv_rd = '0;
  int dv_done = 0, dv_wb = -1;
  int ready_at[32];

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  function automatic string stall_tag(input bit v, input bit rw, input bit ww, input bit rs,
                                      input bit sb, input bit isdiv, input bit busy);
    if (!v) return "R12";
    if (rw) return "R8";
    if (ww) return "R9";
    if (rs) return "R11";
    if (sb) return "R6";
    if (isdiv) return "R5";
    if (busy) return "R7";
    return "R2";
  endfunction

  task automatic step(input bit v, input logic [1:0] k, input bit a1, input logic [4:0] s1,
                      input bit a2, input logic [4:0] s2, input bit du, input logic [4:0] d,
                      output bit issued);
    int slot;
    bit pwb, dwb, isdiv, rw, ww, rs, sb, est, epi, edi, ewv, efd, ef1, ef2, dbusy;
    logic [4:0] pwr, ewr;
    op_valid = v; op_kind = k; src1_use = a1; src1_idx = s1;
    src2_use = a2; src2_idx = s2; dst_use = du; dst_idx = d;
    #1;
    slot = cyc % 8;
    pwb = pw_v[slot]; pwr = pw_r[slot];
    if (dv_act && cyc == dv_done) begin
      dv_wb = pwb ? cyc + 1 : cyc;
      ready_at[dv_rd] = dv_wb;
    end
    dwb   = dv_act && (dv_wb == cyc);
    dbusy = dv_act && !dwb;
    isdiv = k[1];
    rw  = v && ((a1 && ready_at[s1] > cyc) || (a2 && ready_at[s2] > cyc));
    ww  = v && !isdiv && du && dbusy && (d == dv_rd);
    rs  = v && !isdiv && prev_w && dbusy && (dv_wb < 0) && (dv_done == cyc + TRK - 1);
    sb  = v && isdiv && dbusy;
    est = rw || ww || rs || sb;
    epi = v && !est && !isdiv;
    edi = v && !est && isdiv;
    ewv = pwb || dwb;
    ewr = pwb ? pwr : (dwb ? dv_rd : 5'd0);
    efd = !pwb && dwb;
    ef1 = (epi || edi) && a1 && ewv && (ewr == s1);
    ef2 = (epi || edi) && a2 && ewv && (ewr == s2);
    chk(stall_tag(v, rw, ww, rs, sb, isdiv, dbusy), "stall/pipe_issue/div_issue",
        16'({stall, pipe_issue, div_issue}), 16'({est, epi, edi}));
    if (efd) chk((dv_wb == dv_done + 1) ? "R10" : "R5", "div writeback",
                 16'({wb_valid, wb_from_div, wb_reg}), 16'({ewv, efd, ewr}));
    else if (pwb) chk(dv_act && dv_done == cyc ? "R10" : "R3", "pipe writeback",
                      16'({wb_valid, wb_from_div, wb_reg}), 16'({ewv, efd, ewr}));
    else chk("R3", "no writeback", 16'(wb_valid), 16'(0));
    chk("R4", "forward flags", 16'({fwd_src1, fwd_src2}), 16'({ef1, ef2}));
    pw_v[slot] = 0;
    if (epi && du) begin
      pw_v[(cyc + TRK) % 8] = 1;
      pw_r[(cyc + TRK) % 8] = d;
      ready_at[d] = cyc + TRK;
    end
    prev_w = epi && du;
    if (dwb) dv_act = 0;
    if (edi) begin
      dv_act = 1; dv_rd = d; dv_wb = -1;
      dv_done = cyc + (k[0] ? LD : LS);
      ready_at[d] = BIG;
    end
    issued = epi || edi;
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    bit x;
    for (int i = 0; i < n; i++) step(0, 2'b00, 0, 5'd0, 0, 5'd0, 0, 5'd0, x);
  endtask

  task automatic until_go(input logic [1:0] k, input bit a1, input logic [4:0] s1,
                          input bit a2, input logic [4:0] s2, input bit du, input logic [4:0] d);
    bit x;
    x = 0;
    for (int i = 0; i < 40 && !x; i++) step(1, k, a1, s1, a2, s2, du, d, x);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    bit iss, cv, ca1, ca2, cdu;
    logic [1:0] ck;
    logic [4:0] cs1, cs2, cd;
    void'($urandom(32'h5eed));
    for (int r = 0; r < 32; r++) ready_at[r] = 0;
    for (int s = 0; s < 8; s++) begin pw_v[s] = 0; pw_r[s] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk("R1", "stall/strobes", 16'({stall, pipe_issue, div_issue}), 16'(0));
    chk("R1", "wb_valid/fwd", 16'({wb_valid, fwd_src1, fwd_src2}), 16'(0));
    @(negedge clk);

    // R2: independent pipelined ops back to back
    for (int i = 1; i <= 4; i++) step(1, 2'b00, 1, 5'd20, 1, 5'd21, 1, 5'(i), iss);
    idle(4);
    // R4, R8: dependent consumer waits then takes the bypass
    step(1, 2'b01, 0, 5'd0, 0, 5'd0, 1, 5'd5, iss);
    until_go(2'b00, 1, 5'd5, 1, 5'd5, 1, 5'd6);
    // R8: source with use flag clear ignores pending register
    step(1, 2'b00, 0, 5'd6, 0, 5'd6, 0, 5'd0, iss);
    idle(5);
    // R5, R7, R9, R6: divide with parallel work
    step(1, 2'b10, 0, 5'd0, 0, 5'd0, 1, 5'd10, iss);
    for (int i = 0; i < 3; i++) step(1, 2'b00, 0, 5'd0, 0, 5'd0, 1, 5'(11 + i), iss);
    until_go(2'b00, 0, 5'd0, 0, 5'd0, 1, 5'd10);
    until_go(2'b11, 1, 5'd10, 0, 5'd0, 1, 5'd14);
    until_go(2'b10, 0, 5'd0, 0, 5'd0, 1, 5'd15);
    idle(30);
    // R10, R11: write-port clash and slot reservation
    step(1, 2'b10, 0, 5'd0, 0, 5'd0, 1, 5'd16, iss);
    idle(LS - TRK - 1);
    step(1, 2'b00, 0, 5'd0, 0, 5'd0, 1, 5'd17, iss);
    until_go(2'b00, 0, 5'd0, 0, 5'd0, 1, 5'd18);
    until_go(2'b00, 1, 5'd16, 0, 5'd0, 1, 5'd19);
    idle(8);

    // Random traffic, stalled operations are held
    cv = 0; iss = 1; ck = 0; ca1 = 0; ca2 = 0; cdu = 0; cs1 = 0; cs2 = 0; cd = 0;
    for (int n = 0; n < 3000; n++) begin
      if (iss || !cv) begin
        int r;
        cv  = ($urandom_range(0, 9) < 8);
        r   = $urandom_range(0, 19);
        ck  = (r < 2) ? 2'b10 : (r == 2) ? 2'b11 : 2'($urandom_range(0, 1));
        ca1 = $urandom_range(0, 3) != 0; cs1 = 5'($urandom_range(0, 7));
        ca2 = $urandom_range(0, 1) != 0; cs2 = 5'($urandom_range(0, 7));
        cdu = ck[1] ? 1'b1 : ($urandom_range(0, 5) != 0);
        cd  = 5'($urandom_range(0, 7));
      end
      step(cv, ck, ca1, cs1, ca2, cs2, cdu, cd, iss);
    end
    idle(30);
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule